// File: doc/BRIEF.md
# Reference-Counted Line Pinning Table

This block sits beside a set-associative last-level cache and decides which of its lines are pinned. Each way of each set holds a small use counter. When a fetch engine fills a line for an accelerator, it writes that line's counter with the number of element uses still to come. Each time a compute lane finishes an iteration that touched the line, it lowers the counter by one. A line whose counter is nonzero is pinned and must not be chosen as a replacement victim. A line whose counter is zero is free.

The table guards forward progress for the ordinary cores. A pin request is refused whenever granting it would leave its set with no free way. While a request is refused, the stall output is high in the same cycle and the fetch engine holds its request. Decrements from the lanes later free a way and the request goes through. The cache's replacement logic reads a per-set mask of free ways through a query port. Tag matching and the data arrays live elsewhere.

Top module: `line_pin_table`

## Requirements
- R1: After reset every counter is zero, the free mask of every set is all ones, `pin_stall` is low and `dec_err` is low.
- R2: A granted pin writes `pin_cnt` into the counter of (`pin_set`, `pin_way`). A value above 63 is stored as 63, since counters are 6 bits wide and requests are 8 bits wide.
- R3: A decrement of a nonzero counter lowers it by one at the next clock edge. When the counter reaches zero, bit `dec_way` of that set's free mask becomes 1.
- R4: A pin with a nonzero saturated count to a currently free way is refused when that way is the only free way in its set. In the refused case `pin_stall` is high in the same cycle and no counter changes because of the pin.
- R5: A decrement and a pin issued in the same cycle are both applied. The decrement is counted first when the free-way check for the pin is made.
- R6: A decrement of a zero counter leaves every counter unchanged and sets `dec_err`, which stays high until reset.
- R7: Bit w of `qry_free_mask` is 1 exactly when the counter of way w in set `qry_set` is zero. It reflects the registered state with no extra cycle of delay.
- R8: Two kinds of pin are always granted: a pin to a way that is already pinned, and a pin with count zero. Each overwrites the counter. When a decrement and a pin target the same way in the same cycle, the pin's value is what is stored.
- R9: No set ever has an all-zero free mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_vld | input | 1 | Pin request valid |
| pin_set | input | 4 | Set of the pin request |
| pin_way | input | 4 | Way of the pin request |
| pin_cnt | input | 8 | Requested use count, saturated to 63 |
| dec_vld | input | 1 | Decrement request valid |
| dec_set | input | 4 | Set of the decrement |
| dec_way | input | 4 | Way of the decrement |
| qry_set | input | 4 | Set whose free mask is reported |
| qry_free_mask | output | 16 | One bit per way, 1 when the way is free |
| pin_stall | output | 1 | Current pin request is refused |
| dec_err | output | 1 | Sticky flag: a zero counter was decremented |

## Verification
The checker properties assume the control inputs are known after reset. The refusal property is checked only when the query port points at the pin's set and no decrement targets that set, because only then is the pre-decrement mask the one the pin sees. The bench aims most random pins at two sets with small counts, so sets saturate and refusals occur often. It issues decrements mostly to ways its model holds as pinned, and only now and then to a free way to provoke the error flag. Directed runs cover count saturation, a single free way left in a set, and a decrement and a pin arriving together.

// File: rtl/pin_pkg.sv
package pin_pkg;
    localparam int unsigned PIN_SETS_DEF  = 16;
    localparam int unsigned PIN_WAYS_DEF  = 16;
    localparam int unsigned PIN_CNT_W_DEF = 6;
    localparam int unsigned PIN_REQ_W_DEF = 8;
endpackage

// File: rtl/pin_sat.sv
module pin_sat #(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned CNT_W = 6
) (
    input  logic [IN_W-1:0]  req_cnt,
    output logic [CNT_W-1:0] sat_cnt
);
    localparam logic [IN_W-1:0] MAX_IN = IN_W'((1 << CNT_W) - 1);

    always_comb begin
        if (req_cnt > MAX_IN) sat_cnt = '1;
        else                  sat_cnt = CNT_W'(req_cnt);
    end
endmodule

// File: rtl/pin_guard.sv
module pin_guard #(
    parameter int unsigned WAYS  = 16,
    parameter int unsigned CNT_W = 6,
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][CNT_W-1:0] row,
    input  logic [WAY_W-1:0]           way,
    input  logic                       need_pin,
    output logic                       grant
);
    logic [WAYS-1:0] free_mask;

    for (genvar w = 0; w < WAYS; w++) begin : g_free
        assign free_mask[w] = (row[w] == '0);
    end

    always_comb begin
        grant = 1'b1;
        if (need_pin && free_mask[way] && ($countones(free_mask) <= 1))
            grant = 1'b0;
    end
endmodule

// File: rtl/line_pin_table.sv
module line_pin_table
    import pin_pkg::*;
#(
    parameter int unsigned SETS  = PIN_SETS_DEF,
    parameter int unsigned WAYS  = PIN_WAYS_DEF,
    parameter int unsigned CNT_W = PIN_CNT_W_DEF,
    parameter int unsigned REQ_W = PIN_REQ_W_DEF,
    localparam int unsigned SET_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_vld,
    input  logic [SET_W-1:0] pin_set,
    input  logic [WAY_W-1:0] pin_way,
    input  logic [REQ_W-1:0] pin_cnt,
    input  logic             dec_vld,
    input  logic [SET_W-1:0] dec_set,
    input  logic [WAY_W-1:0] dec_way,
    input  logic [SET_W-1:0] qry_set,
    output logic [WAYS-1:0]  qry_free_mask,
    output logic             pin_stall,
    output logic             dec_err
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][CNT_W-1:0] cnt;
        logic                                 err;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    logic [CNT_W-1:0]            sat_cnt;
    logic [WAYS-1:0][CNT_W-1:0]  row_after_dec;
    logic                        grant;

    pin_sat #(.IN_W(REQ_W), .CNT_W(CNT_W)) i_sat (
        .req_cnt (pin_cnt),
        .sat_cnt (sat_cnt)
    );

    // Row of the pin's set as it looks once a same-cycle decrement is applied
    always_comb begin
        row_after_dec = st_q.cnt[pin_set];
        if (dec_vld && (dec_set == pin_set) && (row_after_dec[dec_way] != '0))
            row_after_dec[dec_way] = row_after_dec[dec_way] - CNT_W'(1);
    end

    pin_guard #(.WAYS(WAYS), .CNT_W(CNT_W)) i_guard (
        .row      (row_after_dec),
        .way      (pin_way),
        .need_pin (sat_cnt != '0),
        .grant    (grant)
    );

    always_comb begin
        st_d = st_q;
        if (dec_vld) begin
            if (st_q.cnt[dec_set][dec_way] == '0)
                st_d.err = 1'b1;
            else
                st_d.cnt[dec_set][dec_way] = st_q.cnt[dec_set][dec_way] - CNT_W'(1);
        end
        if (pin_vld && grant)
            st_d.cnt[pin_set][pin_way] = sat_cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_qry
        assign qry_free_mask[w] = (st_q.cnt[qry_set][w] == '0);
    end

    assign pin_stall = pin_vld && !grant;
    assign dec_err   = st_q.err;
endmodule

// File: rtl/pin_table_chk.sv
module pin_table_chk #(
    parameter int unsigned SETS  = 16,
    parameter int unsigned WAYS  = 16,
    parameter int unsigned REQ_W = 8,
    localparam int unsigned SET_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pin_vld,
    input logic [SET_W-1:0] pin_set,
    input logic [WAY_W-1:0] pin_way,
    input logic             dec_vld,
    input logic [SET_W-1:0] dec_set,
    input logic [WAY_W-1:0] dec_way,
    input logic [SET_W-1:0] qry_set,
    input logic [WAYS-1:0]  qry_free_mask,
    input logic             pin_stall,
    input logic             dec_err
);
    // R9
    never_all_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qry_free_mask != '0);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |=> dec_err);

    // R6
    zero_dec_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && (qry_set == dec_set) && qry_free_mask[dec_way]) |=> dec_err);

    // R4
    stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_stall |-> pin_vld);

    // R4
    stall_last_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_stall && (qry_set == pin_set) && !(dec_vld && (dec_set == pin_set)))
        |-> (($countones(qry_free_mask) == 1) && qry_free_mask[pin_way]));

    // R8
    pinned_way_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_vld && (qry_set == pin_set) && !qry_free_mask[pin_way]) |-> !pin_stall);
endmodule

bind line_pin_table pin_table_chk #(.SETS(SETS), .WAYS(WAYS), .REQ_W(REQ_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .pin_vld(pin_vld), .pin_set(pin_set), .pin_way(pin_way),
    .dec_vld(dec_vld), .dec_set(dec_set), .dec_way(dec_way), .qry_set(qry_set),
    .qry_free_mask(qry_free_mask), .pin_stall(pin_stall), .dec_err(dec_err)
);

// File: tb/test_line_pin_table.sv
module test_line_pin_table;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       pin_vld = 0, dec_vld = 0;
    logic [3:0] pin_set = 0, pin_way = 0, dec_set = 0, dec_way = 0, qry_set = 0;
    logic [7:0] pin_cnt = 0;
    logic [15:0] qry_free_mask;
    logic       pin_stall, dec_err;

    int checks = 0, errors = 0;
    int mcnt [16][16];
    bit merr = 0;

    always #5 clk = ~clk;

    line_pin_table i_line_pin_table (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int c);
        return (c > 63) ? 63 : c;
    endfunction

    function automatic bit [15:0] mask_of(input int s);
        bit [15:0] m;
        for (int w = 0; w < 16; w++) m[w] = (mcnt[s][w] == 0);
        return m;
    endfunction

    // expected stall, with a same-cycle decrement counted first
    function automatic bit exp_stall();
        int row [16];
        int nfree;
        if (!pin_vld) return 0;
        for (int w = 0; w < 16; w++) row[w] = mcnt[pin_set][w];
        if (dec_vld && dec_set == pin_set && row[dec_way] != 0) row[dec_way]--;
        nfree = 0;
        for (int w = 0; w < 16; w++) if (row[w] == 0) nfree++;
        return (sat(pin_cnt) != 0) && (row[pin_way] == 0) && (nfree <= 1);
    endfunction

    // drive one cycle at negedge, check mask/stall, update model, pass the edge
    task automatic step(input bit pv, input int ps, input int pw, input int pc,
                        input bit dv, input int ds, input int dw, input int qs,
                        input string req);
        bit st;
        @(negedge clk);
        pin_vld = pv; pin_set = 4'(ps); pin_way = 4'(pw); pin_cnt = 8'(pc);
        dec_vld = dv; dec_set = 4'(ds); dec_way = 4'(dw); qry_set = 4'(qs);
        #1;
        chk(qry_free_mask == mask_of(qs), {req, " R7 mask"}, int'(qry_free_mask), int'(mask_of(qs)));
        chk(dec_err == merr, {req, " R6 err"}, int'(dec_err), int'(merr));
        st = exp_stall();
        chk(pin_stall == st, {req, " R4 stall"}, int'(pin_stall), int'(st));
        if (dv) begin
            if (mcnt[ds][dw] == 0) merr = 1;
            else mcnt[ds][dw]--;
        end
        if (pv && !st) mcnt[ps][pw] = sat(pc);
        @(posedge clk);
    endtask

    task automatic idle_look(input int qs, input string req);
        step(0, 0, 0, 0, 0, 0, 0, qs, req);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        for (int s = 0; s < 16; s++) for (int w = 0; w < 16; w++) mcnt[s][w] = 0;
        repeat (3) @(posedge clk);
        rst_n = 1;
        // R1: reset state for every set
        for (int s = 0; s < 16; s++) idle_look(s, "R1 reset");

        // R2: saturation of a large count, R3: release after exact number of decrements
        step(1, 5, 0, 200, 0, 0, 0, 5, "R2 pin sat");
        idle_look(5, "R2 after pin");
        for (int i = 0; i < 62; i++) step(0, 0, 0, 0, 1, 5, 0, 5, "R3 dec");
        chk(qry_free_mask[0] == 1'b0, "R2 still pinned", int'(qry_free_mask[0]), 0);
        step(0, 0, 0, 0, 1, 5, 0, 5, "R3 last dec");
        idle_look(5, "R3 freed");
        chk(qry_free_mask[0] == 1'b1, "R3 way free", int'(qry_free_mask[0]), 1);

        // R4: fill 15 ways, last free way refused
        for (int w = 0; w < 15; w++) step(1, 3, w, 1, 0, 0, 0, 3, "R4 fill");
        step(1, 3, 15, 2, 0, 0, 0, 3, "R4 refuse");
        idle_look(3, "R4 no change");
        chk(qry_free_mask == 16'h8000, "R4 mask", int'(qry_free_mask), 16'h8000);
        // R8: relock of a pinned way and zero-count pin granted
        step(1, 3, 4, 9, 0, 0, 0, 3, "R8 relock");
        step(1, 3, 15, 0, 0, 0, 0, 3, "R8 zero pin");
        // R5: decrement frees way 0 in same cycle as pin to way 15
        step(1, 3, 15, 3, 1, 3, 0, 3, "R5 same cycle");
        idle_look(3, "R5 after");
        chk(qry_free_mask == 16'h0001, "R5 mask", int'(qry_free_mask), 16'h0001);
        // R8: dec and pin on same way, pin wins
        step(1, 3, 15, 7, 1, 3, 15, 3, "R8 same way");
        idle_look(3, "R8 after");

        // R6: decrement of a free way
        step(0, 0, 0, 0, 1, 9, 2, 9, "R6 zero dec");
        idle_look(9, "R6 sticky");
        chk(dec_err == 1'b1, "R6 flag", int'(dec_err), 1);

        // random mix, pins aimed at few sets to saturate them
        for (int i = 0; i < 4000; i++) begin
            int ps, pw, pc, ds, dw, qs;
            bit pv, dv;
            pv = ($urandom % 3) != 0;
            ps = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 2);
            pw = $urandom % 16;
            pc = ($urandom % 20 == 0) ? int'($urandom % 256) : int'($urandom % 4);
            dv = ($urandom % 2) != 0;
            ds = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 2);
            dw = $urandom % 16;
            if ($urandom % 16 != 0) begin
                for (int k = 0; k < 16; k++)
                    if (mcnt[ds][(dw + k) % 16] != 0) begin dw = (dw + k) % 16; break; end
            end
            qs = ($urandom % 2 == 0) ? ps : int'($urandom % 16);
            step(pv, ps, pw, pc, dv, ds, dw, qs, "R9 random");
            chk(qry_free_mask != 16'h0, "R9 free way", int'(qry_free_mask), 1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule